// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block chooses the analog input channel that an eight-input converter samples on each conversion-start pulse. Configuration arrives over a parallel write port. A control word carries a two-bit mode field, a three-bit channel address and a group of further configuration bits. One mode value turns the following write into a shadow mask instead of a control word.

The block has three ways to pick a channel. In single mode it always reports the addressed channel. In programmable mode it walks upward through the channels marked in the shadow mask and wraps at the end. In consecutive mode it counts from channel 0 up to the addressed channel and wraps. A fourth mode value lets software rewrite the other configuration bits without disturbing a running sequence.

On every start pulse the block presents the chosen channel number together with a one-cycle valid strobe. Once a sequence has been set up it needs no further writes to keep running.

Top module: `conv_sequencer`

## Requirements
- R1: Reset sets `chanValid`, `chanOut` and `cfgOut` to 0, selects single mode, clears the shadow mask and sets the channel pointer to 0. A start pulse after reset with no writes yields channel 0.
- R2: A start pulse raises `chanValid` for exactly the next cycle, and `chanOut` carries the chosen channel in that cycle. Without a start pulse, `chanValid` is low and `chanOut` holds its value.
- R3: Control word layout: bits [2:0] are the channel address, bit 3 is the shadow bit, bit 4 is the sequence bit, and bits [11:5] are the configuration bits. A control write with sequence=0 and shadow=0 selects single mode, in which every start pulse yields the address.
- R4: A control write with sequence=0 and shadow=1 stores its address and makes exactly one following write a shadow write. Bits [7:0] of that write form the mask, and bit i selects channel i. The write after that is decoded as a control word again. Start pulses that arrive while the shadow write is pending yield the address.
- R5: After a nonzero mask is loaded, the first start pulse yields the lowest selected channel. Each later pulse yields the next higher selected channel, wrapping from the highest back to the lowest.
- R6: A shadow write of all zeros leaves the block in single mode, and start pulses yield the stored address.
- R7: A control write with sequence=1 and shadow=1 starts consecutive mode. Start pulses then yield 0, 1, … up to and including the address, then 0 again.
- R8: A control write with sequence=1 and shadow=0 updates only the configuration bits. The mode, the sequence position, the mask and the stored address are left untouched.
- R9: A control write with sequence=0 and shadow=0 ends a running sequence, and later pulses yield its address.
- R10: When a write and a start pulse share a clock, the write takes effect first and the pulse uses the updated state.
- R11: Every control write, whatever its mode field, copies bits [11:5] to `cfgOut` on the next edge. Shadow writes and idle cycles leave `cfgOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe for `wrData` |
| wrData | input | 12 | Control word or shadow mask |
| startPulse | input | 1 | Conversion-start pulse, one cycle |
| chanOut | output | 3 | Channel chosen for the latest start pulse |
| chanValid | output | 1 | High for one cycle after each start pulse |
| cfgOut | output | 7 | Configuration bits from the latest control write |

## Verification
Both results are due exactly one rising edge after their stimulus. The channel and valid strobe follow a start pulse, and the configuration bits follow a control write, even when a write and a pulse share that edge. The bench drives each vector on a falling edge and advances a reference model at the same time. It then compares every output on the next falling edge, which is half a period after the edge that produces the result. Because a written word and a pulse are presented together, the ordering rule R10 is covered both by directed vectors and by random traffic.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_PROG   = 2'd1,
    MD_CONSEC = 2'd2
  } seqMode_e;

  // Mode field codes as {sequence bit, shadow bit}
  localparam logic [1:0] FLD_SINGLE = 2'b00;
  localparam logic [1:0] FLD_SHADOW = 2'b01;
  localparam logic [1:0] FLD_KEEP   = 2'b10;
  localparam logic [1:0] FLD_CONSEC = 2'b11;

  typedef struct packed {
    logic     ldAddr;      // capture channel address
    logic     ldCfg;       // capture configuration bits
    logic     ldMask;      // capture shadow mask
    logic     rewindProg;  // restart programmable walk
    logic     rewindCons;  // restart consecutive count
    logic     fire;        // start pulse this cycle
    seqMode_e fireMode;    // mode the pulse is served in
  } seqStrb_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] modeFld,
  input  logic       maskNonZero,
  input  logic       startPulse,
  output seqStrb_t   strb,
  output seqMode_e   curMode,
  output logic       shadowPend
);

  seqMode_e modeQ, modeN;
  logic     pendQ, pendN;

  always_comb begin
    modeN = modeQ;
    pendN = pendQ;
    strb  = '0;
    if (wrEn) begin
      if (pendQ) begin
        strb.ldMask = 1'b1;
        pendN       = 1'b0;
        if (maskNonZero) begin
          modeN           = MD_PROG;
          strb.rewindProg = 1'b1;
        end else begin
          modeN = MD_SINGLE;
        end
      end else begin
        strb.ldCfg = 1'b1;
        unique case (modeFld)
          FLD_SINGLE: begin
            modeN       = MD_SINGLE;
            strb.ldAddr = 1'b1;
          end
          FLD_SHADOW: begin
            modeN       = MD_SINGLE;
            pendN       = 1'b1;
            strb.ldAddr = 1'b1;
          end
          FLD_CONSEC: begin
            modeN           = MD_CONSEC;
            strb.ldAddr     = 1'b1;
            strb.rewindCons = 1'b1;
          end
          default: ; // keep: sequence untouched
        endcase
      end
    end
    strb.fire     = startPulse;
    strb.fireMode = modeN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MD_SINGLE;
      pendQ <= 1'b0;
    end else begin
      modeQ <= modeN;
      pendQ <= pendN;
    end
  end

  assign curMode    = modeQ;
  assign shadowPend = pendQ;

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter  int NCH   = 8,
  parameter  int CFG_W = 7,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [CH_W-1:0]  wrAddr,
  input  logic [CFG_W-1:0] wrCfg,
  input  logic [NCH-1:0]   wrMask,
  output logic [CH_W-1:0]  chanOut,
  output logic             chanValid,
  output logic [CFG_W-1:0] cfgOut,
  output logic [NCH-1:0]   maskQ,
  output logic [CH_W-1:0]  finalQ
);

  logic [CH_W-1:0]  addrQ, lastQ, chanQ;
  logic [CFG_W-1:0] cfgQ;
  logic             validQ;

  logic [CH_W-1:0]  addrEff, finalEff, lastEff, pick, lastN;
  logic [NCH-1:0]   maskEff;

  // First set bit strictly after 'from', searching upward with wrap
  function automatic logic [CH_W-1:0] nextSet(input logic [NCH-1:0] m,
                                               input logic [CH_W-1:0] from);
    logic            found;
    logic [CH_W-1:0] res;
    found = 1'b0;
    res   = from;
    for (int off = 1; off <= NCH; off++) begin
      logic [CH_W-1:0] idx;
      idx = from + CH_W'(off);
      if (!found && m[idx]) begin
        res   = idx;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    addrEff  = strb.ldAddr ? wrAddr : addrQ;
    maskEff  = strb.ldMask ? wrMask : maskQ;
    finalEff = strb.rewindCons ? wrAddr : finalQ;
    if (strb.rewindProg)      lastEff = {CH_W{1'b1}};
    else if (strb.rewindCons) lastEff = wrAddr;
    else                      lastEff = lastQ;

    unique case (strb.fireMode)
      MD_PROG:   pick = nextSet(maskEff, lastEff);
      MD_CONSEC: pick = (lastEff >= finalEff) ? '0 : lastEff + 1'b1;
      default:   pick = addrEff;
    endcase

    lastN = (strb.fire && strb.fireMode != MD_SINGLE) ? pick : lastEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      maskQ  <= '0;
      finalQ <= '0;
      lastQ  <= '0;
      cfgQ   <= '0;
      chanQ  <= '0;
      validQ <= 1'b0;
    end else begin
      addrQ  <= addrEff;
      maskQ  <= maskEff;
      finalQ <= finalEff;
      lastQ  <= lastN;
      if (strb.ldCfg) cfgQ <= wrCfg;
      validQ <= strb.fire;
      if (strb.fire) chanQ <= pick;
    end
  end

  assign chanOut   = chanQ;
  assign chanValid = validQ;
  assign cfgOut    = cfgQ;

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seq_pkg::*;
#(
  parameter  int NCH    = 8,
  parameter  int CFG_W  = 7,
  localparam int CH_W   = $clog2(NCH),
  localparam int WORD_W = CH_W + 2 + CFG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              startPulse,
  output logic [CH_W-1:0]   chanOut,
  output logic              chanValid,
  output logic [CFG_W-1:0]  cfgOut
);

  seqStrb_t       strb;
  seqMode_e       curMode;
  logic           shadowPend;
  logic [NCH-1:0] maskQ;
  logic [CH_W-1:0] finalQ;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .modeFld    (wrData[CH_W+1:CH_W]),
    .maskNonZero(|wrData[NCH-1:0]),
    .startPulse (startPulse),
    .strb       (strb),
    .curMode    (curMode),
    .shadowPend (shadowPend)
  );

  seq_datapath #(.NCH(NCH), .CFG_W(CFG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrData[CH_W-1:0]),
    .wrCfg    (wrData[WORD_W-1:CH_W+2]),
    .wrMask   (wrData[NCH-1:0]),
    .chanOut  (chanOut),
    .chanValid(chanValid),
    .cfgOut   (cfgOut),
    .maskQ    (maskQ),
    .finalQ   (finalQ)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter  int NCH   = 8,
  parameter  int CFG_W = 7,
  localparam int CH_W  = $clog2(NCH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             startPulse,
  input logic [CH_W-1:0]  chanOut,
  input logic             chanValid,
  input logic [CFG_W-1:0] cfgOut,
  input seqMode_e         fireMode,
  input logic [NCH-1:0]   maskQ,
  input logic [CH_W-1:0]  finalQ,
  input logic             pend
);

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> chanValid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> (!chanValid && $stable(chanOut))); // R2

  AST_PROG_IN_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && fireMode == MD_PROG) |=> maskQ[chanOut]); // R5

  AST_CONSEC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && fireMode == MD_CONSEC) |=> (chanOut <= finalQ)); // R7

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || pend) |=> $stable(cfgOut)); // R11

  AST_PEND_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (pend && wrEn) |=> !pend); // R4

endmodule

bind conv_sequencer seq_checker #(.NCH(NCH), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .startPulse(startPulse),
  .chanOut   (chanOut),
  .chanValid (chanValid),
  .cfgOut    (cfgOut),
  .fireMode  (strb.fireMode),
  .maskQ     (maskQ),
  .finalQ    (finalQ),
  .pend      (shadowPend)
);

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrData = '0;
  logic        startPulse = 1'b0;
  logic [2:0]  chanOut;
  logic        chanValid;
  logic [6:0]  cfgOut;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  conv_sequencer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .startPulse(startPulse), .chanOut(chanOut), .chanValid(chanValid),
    .cfgOut(cfgOut)
  );

  // reference model: 0 single, 1 programmable, 2 consecutive
  int       mMode;
  bit       mPend;
  bit [7:0] mMask;
  int       mAddr, mFinal, mLast;
  bit [6:0] mCfg;
  int       expChan;
  bit       expValid;

  function automatic int lowestAbove(bit [7:0] m, int from);
    for (int c = from + 1; c < 8; c++) if (m[c]) return c;
    for (int c = 0; c <= from; c++) if (m[c]) return c;
    return 0;
  endfunction

  function automatic logic [11:0] ctlWord(bit [6:0] cfg, bit seqB, bit shdB, int addr);
    return {cfg, seqB, shdB, 3'(addr)};
  endfunction

  task automatic modelReset();
    mMode = 0; mPend = 0; mMask = '0; mAddr = 0; mFinal = 0; mLast = 0;
    mCfg = '0; expChan = 0; expValid = 0;
  endtask

  task automatic modelStep(bit w, logic [11:0] d, bit s);
    if (w) begin
      if (mPend) begin
        mPend = 0;
        mMask = d[7:0];
        if (mMask != 0) begin mMode = 1; mLast = 7; end
        else mMode = 0;
      end else begin
        mCfg = d[11:5];
        case (d[4:3])
          2'b00: begin mMode = 0; mAddr = d[2:0]; end
          2'b01: begin mMode = 0; mAddr = d[2:0]; mPend = 1; end
          2'b11: begin mMode = 2; mAddr = d[2:0]; mFinal = mAddr; mLast = mAddr; end
          default: ;
        endcase
      end
    end
    expValid = s;
    if (s) begin
      if (mMode == 0) expChan = mAddr;
      else if (mMode == 1) begin expChan = lowestAbove(mMask, mLast); mLast = expChan; end
      else begin expChan = (mLast >= mFinal) ? 0 : mLast + 1; mLast = expChan; end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, result due one rising edge later
  task automatic step(bit w, logic [11:0] d, bit s, string tag);
    wrEn = w; wrData = d; startPulse = s;
    modelStep(w, d, s);
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; startPulse = 0;
    chk(s ? tag : "R2", "valid", int'(chanValid), int'(expValid));
    chk(s ? tag : "R2", "chan", int'(chanOut), expChan);
    chk(w ? "R11" : tag, "cfg", int'(cfgOut), int'(mCfg));
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!doneFlag) begin
      doneFlag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "valid", int'(chanValid), 0);
    chk("R1", "chan", int'(chanOut), 0);
    chk("R1", "cfg", int'(cfgOut), 0);
    step(0, '0, 1, "R1");

    // R3 single mode
    step(1, ctlWord(7'h2A, 0, 0, 5), 0, "R3");
    step(0, '0, 1, "R3");
    step(0, '0, 0, "R2");
    step(0, '0, 1, "R3");

    // R4 shadow load, start while pending uses address
    step(1, ctlWord(7'h11, 0, 1, 2), 0, "R4");
    step(0, '0, 1, "R4");
    step(1, 12'h0A4, 0, "R4");   // channels 2,5,7
    step(0, '0, 1, "R5");
    step(0, '0, 1, "R5");
    step(0, '0, 1, "R5");
    step(0, '0, 1, "R5");

    // R8 keep: cfg changes, walk continues at 5
    step(1, ctlWord(7'h15, 1, 0, 6), 0, "R8");
    step(0, '0, 1, "R8");
    step(0, '0, 1, "R8");

    // R10 consecutive entry with simultaneous pulse
    step(1, ctlWord(7'h03, 1, 1, 3), 1, "R10");
    step(0, '0, 1, "R7");
    step(0, '0, 1, "R7");
    step(0, '0, 1, "R7");
    step(0, '0, 1, "R7");
    step(1, ctlWord(7'h44, 1, 0, 1), 1, "R8");

    // R9 terminate into single
    step(1, ctlWord(7'h7F, 0, 0, 4), 1, "R9");
    step(0, '0, 1, "R9");

    // R6 zero mask
    step(1, ctlWord(7'h01, 0, 1, 6), 0, "R6");
    step(1, 12'h000, 0, "R6");
    step(0, '0, 1, "R6");
    step(0, '0, 1, "R6");

    // R5 single-bit mask, and write after shadow decoded as control
    step(1, ctlWord(7'h02, 0, 1, 3), 0, "R4");
    step(1, 12'h001, 1, "R10");
    step(0, '0, 1, "R5");
    step(1, ctlWord(7'h09, 0, 0, 7), 1, "R4");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit w, s;
      logic [11:0] d;
      string tag;
      w = ($urandom % 4) == 0;
      s = ($urandom % 2) == 0;
      d = 12'($urandom);
      if (mMode == 1) tag = "R5";
      else if (mMode == 2) tag = "R7";
      else tag = "R3";
      if (w && s) tag = "R10";
      step(w, d, s, tag);
    end

    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule